// File: doc/BRIEF.md
# Streamer Command Sequencer

This block paces a streaming engine through a chain of fixed-length commands. The host sends commands that each carry a clock-cycle duration and an opaque mode word. A command is marked either as a cold start or as a follow-on.

A cold start replaces whatever the engine is doing at the next clock edge. A follow-on command waits in a one-entry holding slot until the running command's time is used up. If a follow-on arrives while nothing is running, it is not parked. It goes straight into the running slot.

When a parked command is promoted into the running slot, the block emits a one-cycle handover event. The event sets a sticky pending flag. The flag reaches the interrupt output only while the host's enable is high, and the host clears it with a one-cycle strobe. A host that wants an uninterrupted chain cold-starts the engine, parks one follow-on, and then enables the interrupt. It re-feeds the holding slot from each handover.

Top module: `strm_cmd_seq`

## Requirements
- R1: After reset, busy, emptyEvent, irqPending and irqOut are 0, activeMode is 0 and cmdReady is 1.
- R2: A start command (cmdValid=1, cmdIsStart=1) is always accepted. From the next cycle, busy=1 and activeMode equals its mode word. With nothing parked, busy stays 1 for exactly cmdCount cycles.
- R3: A duration of 0 is run as 1 cycle.
- R4: A continue command (cmdValid=1, cmdIsStart=0) accepted while busy and not in the last active cycle is parked. activeMode does not change until the running command expires. In the cycle after the last active cycle, the parked mode becomes active and emptyEvent is 1 for that cycle.
- R5: A continue command accepted while idle becomes active at the next edge, and emptyEvent stays 0.
- R6: While a command is parked, cmdReady is 0 for a continue command and 1 for a start command. A refused continue command changes nothing.
- R7: A start command discards any parked command, which then never runs, and cmdReady returns to 1 for continue commands.
- R8: When the running command expires with nothing parked, busy falls to 0 and emptyEvent stays 0.
- R9: Each emptyEvent sets irqPending in the same cycle. irqPending stays set until an irqClear strobe, and a set in the same cycle as a clear wins. irqOut equals irqPending AND irqEnable.
- R10: A continue command accepted in the last active cycle is handed over at the next edge, with emptyEvent=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | A command is presented this cycle |
| cmdIsStart | input | 1 | 1 = cold start, 0 = continue |
| cmdCount | input | CNT_W | Duration in clock cycles (0 runs as 1) |
| cmdMode | input | MODE_W | Opaque mode word |
| cmdReady | output | 1 | Command accepted when high with cmdValid |
| irqEnable | input | 1 | Passes the pending flag to irqOut |
| irqClear | input | 1 | One-cycle strobe that clears irqPending |
| busy | output | 1 | A command is running |
| activeMode | output | MODE_W | Mode word of the running (or last) command |
| emptyEvent | output | 1 | One-cycle pulse on each handover from the holding slot |
| irqPending | output | 1 | Sticky handover flag |
| irqOut | output | 1 | Interrupt to the host |

## Verification
The bench aims at the edges of the handover: a continue command landing exactly in the last active cycle, a one-cycle command, and a zero duration. A design that mishandles any of these drops the command, or runs it without the event, or expires after zero or two cycles. It also targets a continue command issued while idle, where a wrong design would fire a spurious event, and a start that overtakes a parked command, where a wrong design would later run the stale command. Back-to-back handovers with one-cycle durations and clears that collide with new events are also covered, to expose a flag that loses a set or a ready line that admits a second parked command.

// File: rtl/strm_seq_pkg.sv
package strm_seq_pkg;
  typedef struct packed {
    logic actFromCmd;
    logic actFromBuf;
    logic bufFromCmd;
    logic countDown;
  } seqCtrl_t;
endpackage

// File: rtl/strm_seq_dp.sv
module strm_seq_dp
  import strm_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtrl_t          ctrl,
  input  logic              busy,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [MODE_W-1:0] cmdMode,
  output logic [MODE_W-1:0] activeMode,
  output logic              lastCycle
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0]  actRem;
  logic [MODE_W-1:0] actModeQ;
  logic [CNT_W-1:0]  bufCnt;
  logic [MODE_W-1:0] bufMode;

  function automatic logic [CNT_W-1:0] normCount(input logic [CNT_W-1:0] c);
    return (c == '0) ? ONE : c;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actRem   <= '0;
      actModeQ <= '0;
    end else if (ctrl.actFromCmd) begin
      actRem   <= normCount(cmdCount);
      actModeQ <= cmdMode;
    end else if (ctrl.actFromBuf) begin
      actRem   <= bufCnt;
      actModeQ <= bufMode;
    end else if (ctrl.countDown) begin
      actRem   <= actRem - ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufCnt  <= ONE;
      bufMode <= '0;
    end else if (ctrl.bufFromCmd) begin
      bufCnt  <= normCount(cmdCount);
      bufMode <= cmdMode;
    end
  end

  assign activeMode = actModeQ;
  assign lastCycle  = (actRem == ONE);

  // R3: a running command always has time left
  p_rem_nonzero_r3: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (actRem != '0));

  // R4: mode only moves on a load
  p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(ctrl.actFromCmd || ctrl.actFromBuf) |=> $stable(actModeQ));
endmodule

// File: rtl/strm_seq_ctl.sv
module strm_seq_ctl
  import strm_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     cmdIsStart,
  input  logic     lastCycle,
  output logic     cmdReady,
  output seqCtrl_t ctrl,
  output logic     busy,
  output logic     handover
);
  logic busyQ, bufFullQ, busyD, bufFullD;
  logic accept, expire;

  assign cmdReady = cmdIsStart || !bufFullQ;
  assign accept   = cmdValid && cmdReady;
  assign expire   = busyQ && lastCycle;

  always_comb begin
    ctrl     = '0;
    busyD    = busyQ;
    bufFullD = bufFullQ;
    handover = 1'b0;
    if (accept && cmdIsStart) begin
      ctrl.actFromCmd = 1'b1;
      busyD           = 1'b1;
      bufFullD        = 1'b0;
    end else if (accept) begin
      if (!busyQ) begin
        ctrl.actFromCmd = 1'b1;
        busyD           = 1'b1;
      end else if (expire) begin
        ctrl.actFromCmd = 1'b1;
        handover        = 1'b1;
      end else begin
        ctrl.bufFromCmd = 1'b1;
        ctrl.countDown  = 1'b1;
        bufFullD        = 1'b1;
      end
    end else if (busyQ) begin
      if (!expire) begin
        ctrl.countDown = 1'b1;
      end else if (bufFullQ) begin
        ctrl.actFromBuf = 1'b1;
        handover        = 1'b1;
        bufFullD        = 1'b0;
      end else begin
        busyD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyQ    <= 1'b0;
      bufFullQ <= 1'b0;
    end else begin
      busyQ    <= busyD;
      bufFullQ <= bufFullD;
    end
  end

  assign busy = busyQ;

  // R6: something parked implies something running
  p_buf_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    bufFullQ |-> busyQ);

  // R4: a handover only happens out of a running command
  p_handover_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    handover |-> busyQ);

  // R7: a start leaves the holding slot empty
  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdIsStart) |=> !bufFullQ);
endmodule

// File: rtl/strm_seq_irq.sv
module strm_seq_irq (
  input  logic clk,
  input  logic rstN,
  input  logic handover,
  input  logic irqEnable,
  input  logic irqClear,
  output logic emptyEvent,
  output logic irqPending,
  output logic irqOut
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyEvent <= 1'b0;
      irqPending <= 1'b0;
    end else begin
      emptyEvent <= handover;
      irqPending <= handover | (irqPending & ~irqClear);
    end
  end

  assign irqOut = irqPending & irqEnable;

  // R9: event and flag rise together
  p_evt_sets_r9: assert property (@(posedge clk) disable iff (!rstN)
    emptyEvent |-> irqPending);

  // R9: flag is sticky without a clear
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (irqPending && !irqClear) |=> irqPending);
endmodule

// File: rtl/strm_cmd_seq.sv
module strm_cmd_seq
  import strm_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int MODE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdIsStart,
  input  logic [CNT_W-1:0]  cmdCount,
  input  logic [MODE_W-1:0] cmdMode,
  output logic              cmdReady,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic              busy,
  output logic [MODE_W-1:0] activeMode,
  output logic              emptyEvent,
  output logic              irqPending,
  output logic              irqOut
);
  seqCtrl_t ctrl;
  logic     lastCycle;
  logic     handover;

  strm_seq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsStart(cmdIsStart),
    .lastCycle(lastCycle), .cmdReady(cmdReady), .ctrl(ctrl), .busy(busy),
    .handover(handover)
  );

  strm_seq_dp #(.CNT_W(CNT_W), .MODE_W(MODE_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .busy(busy), .cmdCount(cmdCount),
    .cmdMode(cmdMode), .activeMode(activeMode), .lastCycle(lastCycle)
  );

  strm_seq_irq u_irq (
    .clk(clk), .rstN(rstN), .handover(handover), .irqEnable(irqEnable),
    .irqClear(irqClear), .emptyEvent(emptyEvent), .irqPending(irqPending),
    .irqOut(irqOut)
  );
endmodule

// File: tb/tb_strm_cmd_seq.sv
`timescale 1ns/1ps
module tb_strm_cmd_seq;
  localparam int CNT_W  = 8;
  localparam int MODE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdIsStart = 1'b0, irqEnable = 1'b0, irqClear = 1'b0;
  logic [CNT_W-1:0]  cmdCount = '0;
  logic [MODE_W-1:0] cmdMode = '0;
  logic cmdReady, busy, emptyEvent, irqPending, irqOut;
  logic [MODE_W-1:0] activeMode;

  always #2.5 clk = ~clk;

  strm_cmd_seq #(.CNT_W(CNT_W), .MODE_W(MODE_W)) dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdIsStart(cmdIsStart),
    .cmdCount(cmdCount), .cmdMode(cmdMode), .cmdReady(cmdReady),
    .irqEnable(irqEnable), .irqClear(irqClear), .busy(busy),
    .activeMode(activeMode), .emptyEvent(emptyEvent),
    .irqPending(irqPending), .irqOut(irqOut)
  );

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  // reference state, derived from the requirements
  bit mBusy, mBufFull, mEvt, mFlag, mEn;
  int mRem, mMode, mBufRem, mBufMode;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int norm(input int c);
    return (c == 0) ? 1 : c;
  endfunction

  task automatic cmpAll();
    chk("R2 busy", busy, mBusy);
    chk("R4 activeMode", activeMode, mMode);
    chk("R4 emptyEvent", emptyEvent, mEvt);
    chk("R9 irqPending", irqPending, mFlag);
    chk("R9 irqOut", irqOut, mFlag && mEn);
  endtask

  // called at a falling edge: drive, check ready, advance one clock
  task automatic step(input bit v, input bit s, input int cnt, input int md,
                      input bit en, input bit clr);
    bit acc, expire, evt;
    cmdValid = v; cmdIsStart = s; cmdCount = CNT_W'(cnt); cmdMode = MODE_W'(md);
    irqEnable = en; irqClear = clr;
    #1;
    chk("R6 cmdReady", cmdReady, s || !mBufFull);
    acc = v && (s || !mBufFull);
    expire = mBusy && (mRem == 1);
    evt = 0;
    if (acc && s) begin
      mBusy = 1; mRem = norm(cnt); mMode = md; mBufFull = 0;
    end else if (acc) begin
      if (!mBusy) begin
        mBusy = 1; mRem = norm(cnt); mMode = md;
      end else if (expire) begin
        mRem = norm(cnt); mMode = md; evt = 1;
      end else begin
        mBufRem = norm(cnt); mBufMode = md; mBufFull = 1; mRem--;
      end
    end else if (mBusy) begin
      if (!expire) mRem--;
      else if (mBufFull) begin
        mRem = mBufRem; mMode = mBufMode; mBufFull = 0; evt = 1;
      end else mBusy = 0;
    end
    mFlag = evt || (mFlag && !clr);
    mEvt = evt;
    mEn = en;
    @(negedge clk);
    cmpAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, mEn, 0);
  endtask

  task automatic doReset();
    rstN = 0; cmdValid = 0; irqClear = 0; irqEnable = 0;
    mBusy = 0; mBufFull = 0; mEvt = 0; mFlag = 0; mEn = 0;
    mRem = 0; mMode = 0; mBufRem = 1; mBufMode = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    doReset();
    // R1: reset values
    chk("R1 busy", busy, 0);
    chk("R1 activeMode", activeMode, 0);
    chk("R1 emptyEvent", emptyEvent, 0);
    chk("R1 irqPending", irqPending, 0);
    chk("R1 irqOut", irqOut, 0);
    chk("R1 cmdReady", cmdReady, 1);

    // R3: zero duration runs one cycle
    step(1, 1, 0, 8'h3c, 0, 0);
    chk("R3 busy first cycle", busy, 1);
    step(0, 0, 0, 0, 0, 0);
    chk("R3 busy after one cycle", busy, 0);

    // R2: start of length 3 stays busy exactly 3 cycles; R8 then idles without event
    step(1, 1, 3, 8'h11, 0, 0);
    chk("R2 mode", activeMode, 8'h11);
    idle(2);
    chk("R2 still busy", busy, 1);
    idle(1);
    chk("R8 idle", busy, 0);
    chk("R8 no event", emptyEvent, 0);

    // R5: continue while idle loads directly, no event
    step(1, 0, 2, 8'h22, 1, 0);
    chk("R5 busy", busy, 1);
    chk("R5 mode", activeMode, 8'h22);
    chk("R5 no event", emptyEvent, 0);
    idle(2);

    // R4/R6/R9: park, refuse a second continue, handover with event
    step(1, 1, 3, 8'h33, 1, 0);
    step(1, 0, 2, 8'h44, 1, 0);
    step(1, 0, 5, 8'h55, 1, 0);
    chk("R6 refused keeps mode", activeMode, 8'h33);
    step(0, 0, 0, 0, 1, 0);
    chk("R4 handover event", emptyEvent, 1);
    chk("R4 parked mode", activeMode, 8'h44);
    chk("R9 irqOut", irqOut, 1);
    step(0, 0, 0, 0, 0, 1);
    chk("R9 cleared", irqPending, 0);
    idle(2);

    // R7: start discards parked command
    step(1, 1, 4, 8'h66, 0, 0);
    step(1, 0, 4, 8'h77, 0, 0);
    step(1, 1, 2, 8'h88, 0, 0);
    chk("R7 ready again", cmdReady, 1);
    idle(2);
    chk("R7 no stale run", busy, 0);
    chk("R7 no event", emptyEvent, 0);

    // R10: continue on the last active cycle
    step(1, 1, 2, 8'h99, 0, 0);
    idle(1);
    step(1, 0, 1, 8'haa, 0, 0);
    chk("R10 event", emptyEvent, 1);
    chk("R10 mode", activeMode, 8'haa);
    idle(2);

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 3) != 0, ($urandom % 5) == 0, $urandom % 5, $urandom % 256,
           $urandom % 2, ($urandom % 6) == 0);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule